// File: doc/BRIEF.md
# Barrel-Threaded Hash Controller

A small in-order processor that interleaves twelve hardware threads over one shared pipeline stage. All threads run the same program from a common instruction store. Each thread keeps its own instruction pointer, a file of sixteen 16-bit registers, a private 128-byte data region and a halted flag. On every cycle the scheduler picks the next live thread after the one that issued last, and that thread executes one complete instruction.

Besides moves, integer arithmetic, byte memory access and branches, the instruction set has three hash-context instructions (init, feed bytes, finish). They do not compute anything. In one cycle each of them places a descriptor into an external request queue, and a separate hashing engine later consumes it and reads the thread's data region through a read port. When the queue reports full, the hash instruction is not retired, and the thread tries it again on its next turn.

Software loads the program through the instruction write port, pulses `start`, and waits for `busy` to fall.

Top module: `hash_barrel_cpu`

## Requirements
- R1: After reset all threads are halted, `busy` is 0, `reqPush` is 0, and every register and data byte is zero.
- R2: A one-cycle `start` pulse clears every halted flag and sets every instruction pointer to 0. Registers and data bytes keep their values. No instruction issues in the start cycle.
- R3: Exactly one instruction issues per cycle while any thread is live. Threads are served in ascending cyclic order starting after the last issuer, and halted threads are skipped. After `start`, thread 0 issues first.
- R4: Instruction word: opcode in [15:12], rd in [11:8], ra in [7:4], rb in [3:0], and an 8-bit immediate or branch target in [7:0]. Opcodes: 0 HALT, 1 MOVI, 2 ADD, 3 SUB, 4 AND, 5 BNEZ, 6 JMP, 7 LDB, 8 STB, 9 HINIT, 10 HPROC, 11 HFIN, 12 TID. Any other opcode only advances the pointer.
- R5: MOVI writes the zero-extended immediate. ADD, SUB and AND compute rd = ra op rb modulo 2^16. TID writes the issuing thread's index.
- R6: JMP loads the target into the pointer. BNEZ loads the target when rd is non-zero and otherwise falls through.
- R7: LDB zero-extends the byte at offset ra[6:0] of the issuing thread's own region into rd. STB writes rd[7:0] there. Other bytes and other threads' regions are unchanged.
- R8: A hash instruction pushes a 38-bit descriptor {kind[37:36], thread[35:32], argA[31:16], argB[15:0]} in its issue cycle. HINIT has kind 0, argA = rd, argB = 0. HPROC has kind 1, argA = rd (address), argB = ra (length). HFIN has kind 2, argA = rd, argB = 0.
- R9: While `reqFull` is 1, nothing is pushed and a hash instruction leaves its pointer unchanged. It is retried later, so no descriptor is lost or duplicated.
- R10: HALT sets the thread's halted flag, which stays set until the next `start`. `busy` is 0 exactly when all threads are halted, and no descriptor is pushed while it is 0.
- R11: `memRdData` gives, without a clock, the byte at `memRdAddr` in the region of thread `memRdThread`.
- R12: A write on the instruction port stores `imemData` at `imemAddr`, and later issues fetch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart all threads at address 0 |
| imemWe | input | 1 | Instruction store write enable |
| imemAddr | input | 6 | Instruction store write address |
| imemData | input | 16 | Instruction word to write |
| reqFull | input | 1 | Request queue cannot accept a descriptor |
| reqPush | output | 1 | Descriptor valid this cycle |
| reqDesc | output | 38 | Hash request descriptor |
| memRdThread | input | 4 | Thread whose region is read |
| memRdAddr | input | 7 | Byte offset in that region |
| memRdData | output | 8 | Byte read |
| busy | output | 1 | At least one thread is live |

## Verification
Several properties are checked on every cycle: strict successor order while all threads are live, pointer hold on a blocked hash instruction, halted flags staying set between starts, store landing, and the absence of pushes while the queue is full or the block is idle. Other behaviour can only be shown by running a program. This covers the exact cycle count of a whole run, the arithmetic and branch results per thread, the ordered descriptor stream of each thread, and the fact that random back-pressure changes only the timing, not the results.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 4;
  localparam int NUM_REGS = 1 << RIDX_W;
  localparam int IMM_W   = 8;

  typedef enum logic [3:0] {
    OP_HALT  = 4'd0,
    OP_MOVI  = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_AND   = 4'd4,
    OP_BNEZ  = 4'd5,
    OP_JMP   = 4'd6,
    OP_LDB   = 4'd7,
    OP_STB   = 4'd8,
    OP_HINIT = 4'd9,
    OP_HPROC = 4'd10,
    OP_HFIN  = 4'd11,
    OP_TID   = 4'd12
  } opcode_e;

  // strobes and decoded fields handed from control to datapath
  typedef struct packed {
    logic              issue;
    logic              regWe;
    logic              memWe;
    logic              hashPush;
    logic [3:0]        op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [IMM_W-1:0]  imm;
  } ctl_t;
endpackage

// File: rtl/hbc_control.sv
module hbc_control
  import hbc_pkg::*;
#(
  parameter int NUM_THREADS = 12,
  parameter int IMEM_DEPTH  = 64,
  localparam int TW  = $clog2(NUM_THREADS),
  localparam int IAW = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               imemWe,
  input  logic [IAW-1:0]     imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  input  logic               reqFull,
  input  logic               branchTaken,
  output ctl_t               ctl,
  output logic [TW-1:0]      thread,
  output logic               busy
);

  logic [INSTR_W-1:0]     imem [IMEM_DEPTH];
  logic [IAW-1:0]         ipQ [NUM_THREADS];
  logic [NUM_THREADS-1:0] haltedQ;
  logic [TW-1:0]          lastQ;
  logic                   anyLive;
  logic                   isHash;
  logic [INSTR_W-1:0]     instr;
  logic [IAW-1:0]         curIp;
  logic [IAW-1:0]         ipNext;

  // round-robin pick: first live thread after the last issuer
  always_comb begin : pick
    thread  = lastQ;
    anyLive = 1'b0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      logic [TW:0] cand;
      cand = {1'b0, lastQ} + (TW+1)'(k);
      if (cand >= (TW+1)'(NUM_THREADS)) cand = cand - (TW+1)'(NUM_THREADS);
      if (!anyLive && !haltedQ[cand[TW-1:0]]) begin
        thread  = cand[TW-1:0];
        anyLive = 1'b1;
      end
    end
  end

  always_comb begin : decode
    curIp  = ipQ[thread];
    instr  = imem[curIp];
    ctl    = '0;
    ctl.issue = anyLive && !start;
    ctl.op    = instr[15:12];
    ctl.rd    = instr[11:8];
    ctl.ra    = instr[7:4];
    ctl.rb    = instr[3:0];
    ctl.imm   = instr[7:0];
    isHash    = (ctl.op == OP_HINIT) || (ctl.op == OP_HPROC) || (ctl.op == OP_HFIN);
    ctl.regWe = ctl.issue && ((ctl.op == OP_MOVI) || (ctl.op == OP_ADD) ||
                              (ctl.op == OP_SUB) || (ctl.op == OP_AND) ||
                              (ctl.op == OP_LDB) || (ctl.op == OP_TID));
    ctl.memWe    = ctl.issue && (ctl.op == OP_STB);
    ctl.hashPush = ctl.issue && isHash && !reqFull;
  end

  always_comb begin : nextIp
    ipNext = curIp + 1'b1;
    if (ctl.op == OP_JMP || (ctl.op == OP_BNEZ && branchTaken))
      ipNext = ctl.imm[IAW-1:0];
    else if (isHash && reqFull)
      ipNext = curIp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltedQ <= '1;
      lastQ   <= TW'(NUM_THREADS - 1);
      for (int t = 0; t < NUM_THREADS; t++) ipQ[t] <= '0;
    end else if (start) begin
      haltedQ <= '0;
      lastQ   <= TW'(NUM_THREADS - 1);
      for (int t = 0; t < NUM_THREADS; t++) ipQ[t] <= '0;
    end else if (ctl.issue) begin
      ipQ[thread] <= ipNext;
      lastQ       <= thread;
      if (ctl.op == OP_HALT) haltedQ[thread] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (imemWe) imem[imemAddr] <= imemData;
  end

  assign busy = ~&haltedQ;

  // R3: with every thread live, consecutive issues go to successive threads
  a_r3_round_robin: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && $past(ctl.issue) && haltedQ == '0 && $past(haltedQ) == '0)
      |-> thread == (($past(thread) == TW'(NUM_THREADS - 1)) ? TW'(0) : $past(thread) + 1'b1));

  // R9: a blocked hash instruction keeps its pointer
  a_r9_stall_keeps_ip: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && isHash && reqFull) |=> (start || ipQ[$past(thread)] == $past(curIp)));

  // R10: halted flags only clear through start
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (($past(haltedQ) & ~haltedQ) == '0));

  // R2: start wakes every thread at address 0
  a_r2_start_wakes: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (haltedQ == '0 && ipQ[0] == '0));

endmodule

// File: rtl/hbc_datapath.sv
module hbc_datapath
  import hbc_pkg::*;
#(
  parameter int NUM_THREADS = 12,
  parameter int REG_W       = 16,
  parameter int MEM_BYTES   = 128,
  localparam int TW     = $clog2(NUM_THREADS),
  localparam int MAW    = $clog2(MEM_BYTES),
  localparam int DESC_W = 2 + TW + 2 * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [TW-1:0]     thread,
  output logic              branchTaken,
  output logic              reqPush,
  output logic [DESC_W-1:0] reqDesc,
  input  logic [TW-1:0]     memRdThread,
  input  logic [MAW-1:0]    memRdAddr,
  output logic [7:0]        memRdData
);

  logic [REG_W-1:0] rf  [NUM_THREADS][NUM_REGS];
  logic [7:0]       mem [NUM_THREADS][MEM_BYTES];
  logic [REG_W-1:0] rdV, raV, rbV, result;
  logic [MAW-1:0]   byteAddr;
  logic [1:0]       kind;

  always_comb begin : operands
    rdV      = rf[thread][ctl.rd];
    raV      = rf[thread][ctl.ra];
    rbV      = rf[thread][ctl.rb];
    byteAddr = raV[MAW-1:0];
    case (ctl.op)
      OP_MOVI: result = REG_W'(ctl.imm);
      OP_ADD:  result = raV + rbV;
      OP_SUB:  result = raV - rbV;
      OP_AND:  result = raV & rbV;
      OP_LDB:  result = REG_W'(mem[thread][byteAddr]);
      OP_TID:  result = REG_W'(thread);
      default: result = '0;
    endcase
  end

  always_comb begin : hashReq
    kind    = 2'(ctl.op - OP_HINIT);
    reqPush = ctl.hashPush;
    reqDesc = {kind, thread, rdV, (ctl.op == OP_HPROC) ? raV : REG_W'(0)};
  end

  assign branchTaken = ctl.issue && (rdV != '0);
  assign memRdData   = ({1'b0, memRdThread} < (TW+1)'(NUM_THREADS)) ?
                       mem[memRdThread][memRdAddr] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_THREADS; t++)
        for (int r = 0; r < NUM_REGS; r++) rf[t][r] <= '0;
    end else if (ctl.regWe) begin
      rf[thread][ctl.rd] <= result;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_THREADS; t++)
        for (int b = 0; b < MEM_BYTES; b++) mem[t][b] <= '0;
    end else if (ctl.memWe) begin
      mem[thread][byteAddr] <= rdV[7:0];
    end
  end

  // R7: a store is visible at its own thread's offset on the next cycle
  a_r7_store_lands: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWe |=> mem[$past(thread)][$past(byteAddr)] == $past(rdV[7:0]));

endmodule

// File: rtl/hash_barrel_cpu.sv
module hash_barrel_cpu
  import hbc_pkg::*;
#(
  parameter int NUM_THREADS = 12,
  parameter int REG_W       = 16,
  parameter int MEM_BYTES   = 128,
  parameter int IMEM_DEPTH  = 64,
  localparam int TW     = $clog2(NUM_THREADS),
  localparam int MAW    = $clog2(MEM_BYTES),
  localparam int IAW    = $clog2(IMEM_DEPTH),
  localparam int DESC_W = 2 + TW + 2 * REG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               imemWe,
  input  logic [IAW-1:0]     imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  input  logic               reqFull,
  output logic               reqPush,
  output logic [DESC_W-1:0]  reqDesc,
  input  logic [TW-1:0]      memRdThread,
  input  logic [MAW-1:0]     memRdAddr,
  output logic [7:0]         memRdData,
  output logic               busy
);

  ctl_t          ctl;
  logic [TW-1:0] issueThread;
  logic          branchTaken;

  hbc_control #(.NUM_THREADS(NUM_THREADS), .IMEM_DEPTH(IMEM_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .reqFull(reqFull), .branchTaken(branchTaken),
    .ctl(ctl), .thread(issueThread), .busy(busy)
  );

  hbc_datapath #(.NUM_THREADS(NUM_THREADS), .REG_W(REG_W), .MEM_BYTES(MEM_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .thread(issueThread),
    .branchTaken(branchTaken), .reqPush(reqPush), .reqDesc(reqDesc),
    .memRdThread(memRdThread), .memRdAddr(memRdAddr), .memRdData(memRdData)
  );

  // R9: the queue is never written while it reports full
  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    reqFull |-> !reqPush);

  // R10: an idle block pushes nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqPush);

endmodule

// File: tb/tb_hash_barrel_cpu.sv
module tb_hash_barrel_cpu;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 12;
  localparam int PROG_LEN = 28;
  localparam int RUN_CYCLES = 564; // sum over t of (25 + 4t)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        imemWe = 1'b0;
  logic [5:0]  imemAddr = '0;
  logic [15:0] imemData = '0;
  logic        reqFull = 1'b0;
  logic        reqPush;
  logic [37:0] reqDesc;
  logic [3:0]  memRdThread = '0;
  logic [6:0]  memRdAddr = '0;
  logic [7:0]  memRdData;
  logic        busy;

  int checks = 0;
  int fails = 0;
  int descCnt [NT];
  logic [37:0] descLog [NT][4];
  int busyCycles;
  int fullPushes;
  int badThread;

  hash_barrel_cpu dut (
    .clk(clk), .rstN(rstN), .start(start),
    .imemWe(imemWe), .imemAddr(imemAddr), .imemData(imemData),
    .reqFull(reqFull), .reqPush(reqPush), .reqDesc(reqDesc),
    .memRdThread(memRdThread), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] progWord(input int i);
    case (i)
      0:  return 16'hC100; // TID r1
      1:  return 16'h1000; // MOVI r0,0
      2:  return 16'h1501; // MOVI r5,1
      3:  return 16'h1203; // MOVI r2,3
      4:  return 16'h2610; // ADD r6,r1,r0
      5:  return 16'h1400; // MOVI r4,0
      6:  return 16'h5608; // BNEZ r6,8
      7:  return 16'h600B; // JMP 11
      8:  return 16'h2442; // ADD r4,r4,r2
      9:  return 16'h3665; // SUB r6,r6,r5
      10: return 16'h6006; // JMP 6
      11: return 16'h1740; // MOVI r7,0x40
      12: return 16'h8470; // STB r4,[r7]
      13: return 16'h3805; // SUB r8,r0,r5
      14: return 16'h1941; // MOVI r9,0x41
      15: return 16'h8890; // STB r8,[r9]
      16: return 16'h1AF3; // MOVI r10,0xF3
      17: return 16'h4BA1; // AND r11,r10,r1
      18: return 16'h1C42; // MOVI r12,0x42
      19: return 16'h8BC0; // STB r11,[r12]
      20: return 16'h7D70; // LDB r13,[r7]
      21: return 16'h2DDD; // ADD r13,r13,r13
      22: return 16'h1E43; // MOVI r14,0x43
      23: return 16'h8DE0; // STB r13,[r14]
      24: return 16'h9100; // HINIT r1
      25: return 16'hA720; // HPROC r7,r2
      26: return 16'hB900; // HFIN r9
      default: return 16'h0000; // HALT
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic runProgram(input bit stress);
    logic [7:0] lfsr = 8'h5B;
    for (int t = 0; t < NT; t++) descCnt[t] = 0;
    busyCycles = 0;
    fullPushes = 0;
    badThread = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (stress) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        reqFull = lfsr[0];
      end else begin
        reqFull = 1'b0;
      end
      #1;
      if (!busy) break;
      busyCycles++;
      if (reqPush) begin
        if (reqFull) fullPushes++;
        if (reqDesc[35:32] < NT) begin
          if (descCnt[reqDesc[35:32]] < 4) descLog[reqDesc[35:32]][descCnt[reqDesc[35:32]]] = reqDesc;
          descCnt[reqDesc[35:32]]++;
        end else begin
          badThread++;
        end
      end
      @(negedge clk);
    end
    reqFull = 1'b0;
  endtask

  task automatic checkResults();
    for (int t = 0; t < NT; t++) begin
      memRdThread = 4'(t);
      memRdAddr = 7'h40; #1;
      check(memRdData == 8'(3 * t), "R6 R5 R7", "3t loop sum byte", memRdData, 3 * t);
      memRdAddr = 7'h41; #1;
      check(memRdData == 8'hFF, "R5", "0-1 wrap byte", memRdData, 8'hFF);
      memRdAddr = 7'h42; #1;
      check(memRdData == 8'(t & 8'hF3), "R5 R4", "AND with TID", memRdData, t & 8'hF3);
      memRdAddr = 7'h43; #1;
      check(memRdData == 8'(6 * t), "R7 R11", "LDB then doubled", memRdData, 6 * t);
      memRdAddr = 7'h3F; #1;
      check(memRdData == 8'h00, "R7", "byte below stores untouched", memRdData, 0);
      memRdAddr = 7'h44; #1;
      check(memRdData == 8'h00, "R7", "byte above stores untouched", memRdData, 0);
      check(descCnt[t] == 3, "R8 R9", "descriptor count", descCnt[t], 3);
      check(descLog[t][0] == {2'd0, 4'(t), 16'(t), 16'd0}, "R8", "init descriptor",
            descLog[t][0], {2'd0, 4'(t), 16'(t), 16'd0});
      check(descLog[t][1] == {2'd1, 4'(t), 16'h0040, 16'd3}, "R8", "process descriptor",
            descLog[t][1], {2'd1, 4'(t), 16'h0040, 16'd3});
      check(descLog[t][2] == {2'd2, 4'(t), 16'h0041, 16'd0}, "R8", "finish descriptor",
            descLog[t][2], {2'd2, 4'(t), 16'h0041, 16'd0});
    end
    check(badThread == 0, "R8", "descriptor thread in range", badThread, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL R3 watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin : stimulus
    int idlePushes;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(reqPush == 1'b0, "R1", "push in reset", reqPush, 0);
    check(memRdData == 8'h00, "R1 R11", "data byte in reset", memRdData, 0);
    rstN = 1'b1;

    // R12: load the program
    for (int i = 0; i < PROG_LEN; i++) begin
      @(negedge clk);
      imemWe = 1'b1;
      imemAddr = 6'(i);
      imemData = progWord(i);
    end
    @(negedge clk) imemWe = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R2", "idle until start", busy, 0);

    // run without back-pressure
    runProgram(1'b0);
    check(busy == 1'b0, "R10", "all halted after run", busy, 0);
    check(busyCycles == RUN_CYCLES, "R3 R12", "cycles while busy", busyCycles, RUN_CYCLES);
    checkResults();

    // R10: idle block stays quiet
    idlePushes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) #1;
      if (reqPush || busy) idlePushes++;
    end
    check(idlePushes == 0, "R10", "idle activity", idlePushes, 0);

    // run with pseudo-random queue-full back-pressure
    runProgram(1'b1);
    check(busy == 1'b0, "R10", "all halted after stressed run", busy, 0);
    check(busyCycles > RUN_CYCLES, "R9", "retries lengthen run", busyCycles, RUN_CYCLES + 1);
    check(fullPushes == 0, "R9", "pushes while full", fullPushes, 0);
    checkResults();

    summary();
    $finish;
  end
endmodule